// File: doc/BRIEF.md
# T1 Line Transmit Selector

This block decides what the transmit line driver sends on each bit. It chooses between four sources: dual-rail data taken straight from the positive and negative data pins, a single-rail coded stream, a continuous all-ones pattern, or an idle line with the driver disabled. All logic runs on one fast reference clock, which also stands in for the local crystal. The transmit clock and the backup master clock enter as ordinary inputs. They are sampled, and their rising edges are detected in the reference-clock domain.

Three autonomous behaviours sit on top of the source choice. If the negative data input is held high for long enough, the block switches into a single-rail coder mode. If the transmit clock stops, a watchdog disables the line. Any change to the transmit controls raises a settling-busy flag for a fixed number of bit periods. An all-ones request, taken from a pin or from a host register bit, overrides the data inputs unless remote loopback is active. The all-ones timing falls back from the transmit clock to the master clock, and then to the local reference.

Top module: `t1tx_line_ctrl`

## Requirements
- R1: `coder_mode_o` rises after the negative data input is sampled high on more than `CODER_HOLD` (default 16) consecutive transmit-clock rising edges; 16 such edges leave it low and 17 set it.
- R2: Coder mode clears after a single transmit-clock edge on which the negative data input is sampled low.
- R3: In coder mode the positive data input is single-rail data: a 1 produces one mark, on `pulse_p_o` or `pulse_n_o` alternately, starting with `pulse_p_o` after reset; a 0 produces no pulse.
- R4: After `LOSS_BITS` (default 175) backup bit periods with no transmit-clock edge, `line_oe_o` goes low and both pulse outputs are 0 unless all-ones is active; the first transmit-clock edge restores the line; 174 periods leave it enabled.
- R5: In host mode (`host_mode_i`=1) the high-impedance register bit `cfg_hiz_i`=1 forces `line_oe_o`=0 and both pulse outputs to 0, even during all-ones; in hardware mode that bit has no effect.
- R6: While all-ones is in effect, every bit period carries exactly one mark, and the polarity alternates between successive bits, whatever the data inputs are.
- R7: While `rloop_i`=1, an all-ones request is ignored and dual-rail data passes through.
- R8: The all-ones request comes from `aos_pin_i` in hardware mode and from `cfg_aos_i` in host mode; the other source has no effect.
- R9: `timing_src_o` reports the bit timing source: 0 = transmit clock, 1 = master clock (transmit clock lost), 2 = local reference (both lost). All-ones keeps the line enabled and marking from the backup source.
- R10: A change on the all-ones request, `len_sel_i` or `lloop_i` sets `settle_busy_o` for `SETTLE_BITS` (default 22) bit periods, counted from the last change: busy after 21 periods, clear after 22.
- R11: After reset, both pulse outputs are 0, `line_oe_o`=1, `coder_mode_o`=0, `settle_busy_o`=0 and `timing_src_o`=0.
- R12: In normal dual-rail mode, each transmit-clock edge copies the sampled positive and negative data inputs onto `pulse_p_o` and `pulse_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the local timing source |
| rst_n | input | 1 | Active-low reset |
| tclk_i | input | 1 | Transmit bit clock, sampled |
| mclk_i | input | 1 | Backup master clock, sampled |
| tpos_i | input | 1 | Positive rail data, or single-rail data in coder mode |
| tneg_i | input | 1 | Negative rail data, held high to request coder mode |
| aos_pin_i | input | 1 | All-ones request pin (hardware mode) |
| host_mode_i | input | 1 | 1 = host mode, 0 = hardware mode |
| cfg_aos_i | input | 1 | All-ones register bit (host mode) |
| cfg_hiz_i | input | 1 | High-impedance register bit (host mode) |
| rloop_i | input | 1 | Remote loopback active |
| len_sel_i | input | LEN_W | Line length selection |
| lloop_i | input | 1 | Local loopback control |
| pulse_p_o | output | 1 | Positive pulse enable to the driver |
| pulse_n_o | output | 1 | Negative pulse enable to the driver |
| line_oe_o | output | 1 | Driver output enable (0 = high impedance) |
| coder_mode_o | output | 1 | Single-rail coder mode active |
| settle_busy_o | output | 1 | Transmit output settling after a control change |
| timing_src_o | output | 2 | Bit timing source in use |

## Verification
The hardest state to reach from the ports is all-ones marking driven by the local reference. It needs the transmit clock to be declared lost first, and then the master clock as well. The stimulus stops the transmit clock while the master clock keeps ticking in step with each bit, so the 174/175 boundary falls on an exact bit. It then raises the all-ones pin and silences the master clock long enough for its loss counter to expire, and watches the marks keep alternating at the local rate. The coder threshold is swept over every run length from 0 to 20 to pin the boundary between 16 and 17.

// File: rtl/t1tx_pkg.sv
package t1tx_pkg;

  typedef enum logic [1:0] {
    TSRC_TCLK  = 2'd0,
    TSRC_MCLK  = 2'd1,
    TSRC_LOCAL = 2'd2
  } tsrc_e;

  typedef struct packed {
    logic p;
    logic n;
    logic flip;
  } mark_t;

  // Which clock times the bits, given the two loss flags.
  function automatic tsrc_e pick_src(input logic tclk_lost, input logic mclk_lost);
    if (!tclk_lost)     return TSRC_TCLK;
    else if (!mclk_lost) return TSRC_MCLK;
    else                return TSRC_LOCAL;
  endfunction

  // One alternating mark; alt=0 means positive next.
  function automatic mark_t alt_mark(input logic alt);
    mark_t m;
    m.p    = ~alt;
    m.n    = alt;
    m.flip = 1'b1;
    return m;
  endfunction

  // Line decision for one bit period, in priority order.
  function automatic mark_t line_pick(input logic aos, input logic lost, input logic coder,
                                     input logic tp, input logic tn, input logic alt);
    mark_t m;
    m = '0;
    if (aos) begin
      m = alt_mark(alt);
    end else if (lost) begin
      m = '0;
    end else if (coder) begin
      if (tp) m = alt_mark(alt);
    end else begin
      m.p = tp;
      m.n = tn;
    end
    return m;
  endfunction

  // Run length beyond which coder mode engages.
  function automatic logic run_exceeds(input int unsigned run, input int unsigned hold);
    return run > hold;
  endfunction

endpackage

// File: rtl/t1tx_tick_gen.sv
module t1tx_tick_gen #(
  parameter int MCLK_LOSS_CYC = 64,
  parameter int LOCAL_DIV     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_i,
  input  logic mclk_i,
  input  logic tpos_i,
  input  logic tneg_i,
  input  logic tclk_lost,
  output logic t_rise,
  output logic backup_tick,
  output logic bit_tick,
  output logic mclk_lost,
  output logic tpos_s,
  output logic tneg_s
);
  localparam int MW = $clog2(MCLK_LOSS_CYC + 1);
  localparam int DW = (LOCAL_DIV > 1) ? $clog2(LOCAL_DIV) : 1;

  logic          tclk_s, tclk_d, mclk_s, mclk_d;
  logic          m_rise, local_tick;
  logic [MW-1:0] miss_q;
  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tclk_s <= 1'b0;
      tclk_d <= 1'b0;
      mclk_s <= 1'b0;
      mclk_d <= 1'b0;
      tpos_s <= 1'b0;
      tneg_s <= 1'b0;
    end else begin
      tclk_s <= tclk_i;
      tclk_d <= tclk_s;
      mclk_s <= mclk_i;
      mclk_d <= mclk_s;
      tpos_s <= tpos_i;
      tneg_s <= tneg_i;
    end
  end

  assign t_rise = tclk_s & ~tclk_d;
  assign m_rise = mclk_s & ~mclk_d;

  // Master clock loss: reference cycles since the last master edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         miss_q <= '0;
    else if (m_rise)                    miss_q <= '0;
    else if (miss_q != MW'(MCLK_LOSS_CYC)) miss_q <= miss_q + 1'b1;
  end
  assign mclk_lost = (miss_q == MW'(MCLK_LOSS_CYC));

  // Local reference divider.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         div_q <= '0;
    else if (div_q == DW'(LOCAL_DIV - 1)) div_q <= '0;
    else                                div_q <= div_q + 1'b1;
  end
  assign local_tick = (div_q == DW'(LOCAL_DIV - 1));

  assign backup_tick = mclk_lost ? local_tick : m_rise;
  assign bit_tick    = tclk_lost ? backup_tick : t_rise;

endmodule

// File: rtl/t1tx_clk_watch.sv
module t1tx_clk_watch #(
  parameter int LOSS_BITS = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic t_rise,
  input  logic backup_tick,
  output logic tclk_lost
);
  localparam int LW = $clog2(LOSS_BITS + 1);

  logic [LW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      tclk_lost <= 1'b0;
    end else if (t_rise) begin
      gap_q     <= '0;
      tclk_lost <= 1'b0;
    end else if (backup_tick && !tclk_lost) begin
      if (gap_q == LW'(LOSS_BITS - 1)) tclk_lost <= 1'b1;
      else                             gap_q <= gap_q + 1'b1;
    end
  end

endmodule

// File: rtl/t1tx_coder_det.sv
module t1tx_coder_det #(
  parameter int CODER_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic t_rise,
  input  logic tneg_s,
  output logic coder_mode
);
  import t1tx_pkg::*;

  localparam int RW = $clog2(CODER_HOLD + 2);

  logic [RW-1:0] run_q, run_nx;

  always_comb begin
    run_nx = run_q;
    if (run_q != RW'(CODER_HOLD + 1)) run_nx = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      coder_mode <= 1'b0;
    end else if (t_rise) begin
      if (tneg_s) begin
        run_q <= run_nx;
        if (run_exceeds(int'(run_nx), CODER_HOLD)) coder_mode <= 1'b1;
      end else begin
        run_q      <= '0;
        coder_mode <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/t1tx_settle.sv
module t1tx_settle #(
  parameter int CTRL_W      = 5,
  parameter int SETTLE_BITS = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              bit_tick,
  output logic              ctrl_change,
  output logic              settle_busy
);
  localparam int SW = $clog2(SETTLE_BITS + 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic              primed_q;
  logic [SW-1:0]     left_q;

  assign ctrl_change = primed_q & (ctrl_i != ctrl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      primed_q <= 1'b0;
      left_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_i;
      primed_q <= 1'b1;
      if (ctrl_change)                left_q <= SW'(SETTLE_BITS);
      else if (bit_tick && left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign settle_busy = (left_q != '0);

endmodule

// File: rtl/t1tx_line_ctrl.sv
module t1tx_line_ctrl #(
  parameter int CODER_HOLD    = 16,
  parameter int LOSS_BITS     = 175,
  parameter int SETTLE_BITS   = 22,
  parameter int MCLK_LOSS_CYC = 64,
  parameter int LOCAL_DIV     = 8,
  parameter int LEN_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tclk_i,
  input  logic             mclk_i,
  input  logic             tpos_i,
  input  logic             tneg_i,
  input  logic             aos_pin_i,
  input  logic             host_mode_i,
  input  logic             cfg_aos_i,
  input  logic             cfg_hiz_i,
  input  logic             rloop_i,
  input  logic [LEN_W-1:0] len_sel_i,
  input  logic             lloop_i,
  output logic             pulse_p_o,
  output logic             pulse_n_o,
  output logic             line_oe_o,
  output logic             coder_mode_o,
  output logic             settle_busy_o,
  output logic [1:0]       timing_src_o
);
  import t1tx_pkg::*;

  localparam int CTRL_W = LEN_W + 2;

  // Named internal events, also watched by the checker.
  logic t_rise, backup_tick, bit_tick, mclk_lost, tclk_lost;
  logic tpos_s, tneg_s;
  logic coder_mode, settle_busy, ctrl_change;
  logic aos_req, aos_eff, hiz_force;
  logic pulse_p_q, pulse_n_q, alt_q;
  mark_t pick;
  tsrc_e src;
  logic [CTRL_W-1:0] ctrl_vec;

  t1tx_tick_gen #(
    .MCLK_LOSS_CYC (MCLK_LOSS_CYC),
    .LOCAL_DIV     (LOCAL_DIV)
  ) u_tick (
    .clk         (clk),
    .rst_n       (rst_n),
    .tclk_i      (tclk_i),
    .mclk_i      (mclk_i),
    .tpos_i      (tpos_i),
    .tneg_i      (tneg_i),
    .tclk_lost   (tclk_lost),
    .t_rise      (t_rise),
    .backup_tick (backup_tick),
    .bit_tick    (bit_tick),
    .mclk_lost   (mclk_lost),
    .tpos_s      (tpos_s),
    .tneg_s      (tneg_s)
  );

  t1tx_clk_watch #(.LOSS_BITS(LOSS_BITS)) u_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .t_rise      (t_rise),
    .backup_tick (backup_tick),
    .tclk_lost   (tclk_lost)
  );

  t1tx_coder_det #(.CODER_HOLD(CODER_HOLD)) u_coder (
    .clk        (clk),
    .rst_n      (rst_n),
    .t_rise     (t_rise),
    .tneg_s     (tneg_s),
    .coder_mode (coder_mode)
  );

  // All-ones request source and loopback override.
  assign aos_req   = host_mode_i ? cfg_aos_i : aos_pin_i;
  assign aos_eff   = aos_req & ~rloop_i;
  assign hiz_force = host_mode_i & cfg_hiz_i;

  assign ctrl_vec = {aos_req, lloop_i, len_sel_i};

  t1tx_settle #(
    .CTRL_W      (CTRL_W),
    .SETTLE_BITS (SETTLE_BITS)
  ) u_settle (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl_vec),
    .bit_tick    (bit_tick),
    .ctrl_change (ctrl_change),
    .settle_busy (settle_busy)
  );

  assign pick = line_pick(aos_eff, tclk_lost, coder_mode, tpos_s, tneg_s, alt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_p_q <= 1'b0;
      pulse_n_q <= 1'b0;
      alt_q     <= 1'b0;
    end else if (bit_tick) begin
      pulse_p_q <= pick.p;
      pulse_n_q <= pick.n;
      if (pick.flip) alt_q <= ~alt_q;
    end
  end

  assign src = pick_src(tclk_lost, mclk_lost);

  assign line_oe_o     = ~hiz_force & (~tclk_lost | aos_eff);
  assign pulse_p_o     = pulse_p_q & line_oe_o;
  assign pulse_n_o     = pulse_n_q & line_oe_o;
  assign coder_mode_o  = coder_mode;
  assign settle_busy_o = settle_busy;
  assign timing_src_o  = src;

endmodule

// File: rtl/t1tx_line_chk.sv
module t1tx_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       t_rise,
  input logic       tpos_s,
  input logic       tneg_s,
  input logic       aos_eff,
  input logic       coder_mode,
  input logic       tclk_lost,
  input logic       ctrl_change,
  input logic       settle_busy,
  input logic       pulse_p_q,
  input logic       pulse_n_q,
  input logic       rloop_i,
  input logic       host_mode_i,
  input logic       cfg_hiz_i,
  input logic       line_oe_o,
  input logic       pulse_p_o,
  input logic       pulse_n_o,
  input logic [1:0] timing_src_o
);
  logic last_aos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_aos_q <= 1'b0;
    else if (bit_tick) last_aos_q <= aos_eff;
  end

  p_coder_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coder_mode) |-> $past(t_rise && tneg_s));

  p_coder_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_rise && !tneg_s) |=> !coder_mode);

  p_lost_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    t_rise |=> !tclk_lost);

  p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode_i && cfg_hiz_i) |-> (!line_oe_o && !pulse_p_o && !pulse_n_o));

  p_one_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && aos_eff) |=> $countones({pulse_p_q, pulse_n_q}) == 1);

  p_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && aos_eff && last_aos_q) |=>
      (pulse_p_q == $past(pulse_n_q)) && (pulse_n_q == $past(pulse_p_q)));

  p_loop_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && rloop_i && !coder_mode && !tclk_lost) |=>
      (pulse_p_q == $past(tpos_s)) && (pulse_n_q == $past(tneg_s)));

  p_src_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timing_src_o != 2'd3);

  p_settle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_change |=> settle_busy);

endmodule

bind t1tx_line_ctrl t1tx_line_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .t_rise       (t_rise),
  .tpos_s       (tpos_s),
  .tneg_s       (tneg_s),
  .aos_eff      (aos_eff),
  .coder_mode   (coder_mode),
  .tclk_lost    (tclk_lost),
  .ctrl_change  (ctrl_change),
  .settle_busy  (settle_busy),
  .pulse_p_q    (pulse_p_q),
  .pulse_n_q    (pulse_n_q),
  .rloop_i      (rloop_i),
  .host_mode_i  (host_mode_i),
  .cfg_hiz_i    (cfg_hiz_i),
  .line_oe_o    (line_oe_o),
  .pulse_p_o    (pulse_p_o),
  .pulse_n_o    (pulse_n_o),
  .timing_src_o (timing_src_o)
);

// File: tb/sim_t1tx_line_ctrl.sv
`timescale 1ns/1ps
module sim_t1tx_line_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tclk_i = 1'b0, mclk_i = 1'b0, tpos_i = 1'b0, tneg_i = 1'b0;
  logic       aos_pin_i = 1'b0, host_mode_i = 1'b0, cfg_aos_i = 1'b0, cfg_hiz_i = 1'b0;
  logic       rloop_i = 1'b0, lloop_i = 1'b0;
  logic [2:0] len_sel_i = 3'd0;
  logic       pulse_p_o, pulse_n_o, line_oe_o, coder_mode_o, settle_busy_o;
  logic [1:0] timing_src_o;

  logic mclk_run = 1'b1;
  int   total = 0;
  int   bad = 0;
  int   cyc = 0;

  always #4 clk = ~clk;

  t1tx_line_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tclk_i(tclk_i), .mclk_i(mclk_i),
    .tpos_i(tpos_i), .tneg_i(tneg_i), .aos_pin_i(aos_pin_i),
    .host_mode_i(host_mode_i), .cfg_aos_i(cfg_aos_i), .cfg_hiz_i(cfg_hiz_i),
    .rloop_i(rloop_i), .len_sel_i(len_sel_i), .lloop_i(lloop_i),
    .pulse_p_o(pulse_p_o), .pulse_n_o(pulse_n_o), .line_oe_o(line_oe_o),
    .coder_mode_o(coder_mode_o), .settle_busy_o(settle_busy_o),
    .timing_src_o(timing_src_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One bit period: 4 reference cycles, clocks high for the first two.
  task automatic run_bit(input logic tc, input logic tp, input logic tn);
    @(negedge clk);
    tclk_i = tc; mclk_i = mclk_run; tpos_i = tp; tneg_i = tn;
    @(negedge clk);
    @(negedge clk);
    tclk_i = 1'b0; mclk_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tclk_i = 0; mclk_i = 0; tpos_i = 0; tneg_i = 0; aos_pin_i = 0;
    host_mode_i = 0; cfg_aos_i = 0; cfg_hiz_i = 0; rloop_i = 0; lloop_i = 0;
    len_sel_i = 3'd0; mclk_run = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic prev_p, prev_n, alt;
    int   flips;
    do_reset();

    // R11 reset state
    check("R11 pulse_p", pulse_p_o, 0);
    check("R11 pulse_n", pulse_n_o, 0);
    check("R11 line_oe", line_oe_o, 1);
    check("R11 coder", coder_mode_o, 0);
    check("R11 busy", settle_busy_o, 0);
    check("R11 src", timing_src_o, 0);

    // R12 dual-rail pass-through, all data combinations
    for (int k = 0; k < 8; k++) begin
      run_bit(1'b1, k[0], k[1]);
      check("R12 pulse_p", pulse_p_o, k[0]);
      check("R12 pulse_n", pulse_n_o, k[1]);
    end

    // R5 host-mode high impedance
    host_mode_i = 1; cfg_hiz_i = 1;
    run_bit(1'b1, 1'b1, 1'b0);
    check("R5 oe host", line_oe_o, 0);
    check("R5 pulse_p host", pulse_p_o, 0);
    host_mode_i = 1; cfg_aos_i = 1;
    run_bit(1'b1, 1'b0, 1'b0);
    check("R5 oe host aos", line_oe_o, 0);
    cfg_aos_i = 0; host_mode_i = 0;
    run_bit(1'b1, 1'b1, 1'b0);
    check("R5 oe hw ignores", line_oe_o, 1);
    check("R5 pulse_p hw", pulse_p_o, 1);
    cfg_hiz_i = 0;

    // R8 request source selection
    host_mode_i = 1; aos_pin_i = 1; cfg_aos_i = 0;
    run_bit(1'b1, 1'b1, 1'b0);
    check("R8 pin ignored host p", pulse_p_o, 1);
    check("R8 pin ignored host n", pulse_n_o, 0);
    run_bit(1'b1, 1'b0, 1'b1);
    check("R8 pin ignored host p2", pulse_p_o, 0);
    aos_pin_i = 0; cfg_aos_i = 1;
    run_bit(1'b1, 1'b0, 1'b0);
    check("R8 reg aos host", pulse_p_o + pulse_n_o, 1);
    host_mode_i = 0;
    run_bit(1'b1, 1'b0, 1'b0);
    check("R8 reg ignored hw p", pulse_p_o, 0);
    check("R8 reg ignored hw n", pulse_n_o, 0);
    cfg_aos_i = 0;

    // R7 loopback overrides all-ones
    aos_pin_i = 1; rloop_i = 1;
    run_bit(1'b1, 1'b0, 1'b1);
    check("R7 p", pulse_p_o, 0);
    check("R7 n", pulse_n_o, 1);
    run_bit(1'b1, 1'b1, 1'b1);
    check("R7 both", pulse_p_o + pulse_n_o, 2);
    rloop_i = 0;

    // R6 all-ones ignores data, alternates
    run_bit(1'b1, 1'b0, 1'b0);
    prev_p = pulse_p_o; prev_n = pulse_n_o;
    check("R6 first mark", prev_p + prev_n, 1);
    for (int k = 0; k < 8; k++) begin
      run_bit(1'b1, k[0], k[1]);
      check("R6 one mark", pulse_p_o + pulse_n_o, 1);
      check("R6 alternate", pulse_p_o, prev_n);
      prev_p = pulse_p_o; prev_n = pulse_n_o;
    end
    aos_pin_i = 0;
    for (int k = 0; k < 25; k++) run_bit(1'b1, 1'b0, 1'b0);

    // R10 settle busy window
    check("R10 idle", settle_busy_o, 0);
    len_sel_i = 3'd1;
    for (int k = 0; k < 21; k++) run_bit(1'b1, 1'b0, 1'b0);
    check("R10 len 21", settle_busy_o, 1);
    run_bit(1'b1, 1'b0, 1'b0);
    check("R10 len 22", settle_busy_o, 0);
    lloop_i = 1;
    for (int k = 0; k < 10; k++) run_bit(1'b1, 1'b0, 1'b0);
    check("R10 lloop mid", settle_busy_o, 1);
    len_sel_i = 3'd5;
    for (int k = 0; k < 21; k++) run_bit(1'b1, 1'b0, 1'b0);
    check("R10 retrigger 21", settle_busy_o, 1);
    run_bit(1'b1, 1'b0, 1'b0);
    check("R10 retrigger 22", settle_busy_o, 0);
    aos_pin_i = 1;
    for (int k = 0; k < 21; k++) run_bit(1'b1, 1'b0, 1'b0);
    check("R10 aos 21", settle_busy_o, 1);
    run_bit(1'b1, 1'b0, 1'b0);
    check("R10 aos 22", settle_busy_o, 0);
    aos_pin_i = 0; lloop_i = 0;

    // R1 threshold sweep
    do_reset();
    for (int k = 0; k <= 20; k++) begin
      run_bit(1'b1, 1'b0, 1'b0);
      for (int j = 0; j < k; j++) run_bit(1'b1, 1'b0, 1'b1);
      check($sformatf("R1 run %0d", k), coder_mode_o, (k > 16) ? 1 : 0);
    end

    // R3 single-rail data with alternating marks
    alt = 1'b0;
    for (int k = 0; k < 6; k++) begin
      logic d;
      d = (k == 1 || k == 4) ? 1'b0 : 1'b1;
      run_bit(1'b1, d, 1'b1);
      check("R3 p", pulse_p_o, d & ~alt);
      check("R3 n", pulse_n_o, d & alt);
      if (d) alt = ~alt;
    end

    // R2 exit on one low sample
    run_bit(1'b1, 1'b0, 1'b0);
    check("R2 exit", coder_mode_o, 0);
    run_bit(1'b1, 1'b1, 1'b0);
    check("R2 dual p", pulse_p_o, 1);
    check("R2 dual n", pulse_n_o, 0);

    // R4 / R9 transmit clock loss boundary
    run_bit(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 174; k++) run_bit(1'b0, 1'b1, 1'b0);
    check("R4 174 oe", line_oe_o, 1);
    check("R9 174 src", timing_src_o, 0);
    run_bit(1'b0, 1'b1, 1'b0);
    check("R4 175 oe", line_oe_o, 0);
    check("R4 175 p", pulse_p_o, 0);
    check("R9 mclk src", timing_src_o, 1);

    aos_pin_i = 1;
    run_bit(1'b0, 1'b0, 1'b0);
    prev_n = pulse_n_o;
    check("R9 aos oe", line_oe_o, 1);
    for (int k = 0; k < 3; k++) begin
      run_bit(1'b0, 1'b0, 1'b0);
      check("R9 aos mclk mark", pulse_p_o + pulse_n_o, 1);
      check("R9 aos mclk alt", pulse_p_o, prev_n);
      prev_n = pulse_n_o;
    end

    mclk_run = 1'b0;
    for (int k = 0; k < 20; k++) run_bit(1'b0, 1'b0, 1'b0);
    check("R9 local src", timing_src_o, 2);
    flips = 0;
    prev_p = pulse_p_o;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (pulse_p_o != prev_p) flips++;
      prev_p = pulse_p_o;
    end
    check("R9 local marking", (flips >= 2) ? 1 : 0, 1);
    check("R9 local one mark", pulse_p_o + pulse_n_o, 1);
    check("R9 local oe", line_oe_o, 1);

    aos_pin_i = 0; mclk_run = 1'b1;
    run_bit(1'b1, 1'b1, 1'b0);
    check("R4 restore oe", line_oe_o, 1);
    check("R9 restore src", timing_src_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule